// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block forms the full-width product of two unsigned operands with a single adder that is reused over many clock cycles. It keeps a multiplicand register, a multiplier register that shifts toward its low end, and an accumulator that carries one extra bit for the adder's carry. Each iteration looks at the multiplier's lowest bit, adds the multiplicand into the accumulator only when that bit is set, and then shifts the carry, accumulator and multiplier right together by one place. After one iteration per operand bit, the accumulator and multiplier registers together hold the product, which is copied to a result register.

A separate control unit sequences the datapath. It is a Moore state machine, so its outputs depend only on its present state. Each datapath register has its own enable and mode lines from the controller: mode 1 loads the register from its parallel input, and mode 0 loads it from its shift path. An iteration counter is a second state variable. It only steers the choice of the next state. Operands enter through a valid/ready handshake. `start_ready` is high only while the block is waiting. A request raised while `start_ready` is low is not taken and leaves no trace, so the requester must hold `start_valid` and the operands until it sees `start_ready` high at a clock edge. The result side is a plain one-cycle `done` flag with no back-pressure.

Top module: `shiftadd_mult`

## Requirements
- R1: When `done` is high, `product` equals `op_a` × `op_b` as unsigned numbers, with W-bit operands and a 2W-bit product (W = 8 by default). The operands are the values sampled at the accepting edge.
- R2: The operands are sampled only on the rising clock edge where `start_valid` and `start_ready` are both high. Changes on `op_a` and `op_b` after that edge do not affect the result.
- R3: `start_ready` is low from the accepting edge until the operation's `done` cycle. A `start_valid` raised during that time is not accepted and yields no additional `done` pulse.
- R4: `done` goes high exactly 2W+1 clock cycles after the accepting edge (17 for W = 8): W add-or-skip cycles, W shift cycles, one result-transfer cycle.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: `product` changes only at the edge that raises `done`. It holds its value through later idle and busy cycles until the next operation completes.
- R7: The active-low `rst_n` is asynchronous. While it is low and after it is released, `done` is 0, `product` is 0 and `start_ready` is 1.
- R8: Boundary operands give exact results, including 255 × 255 = 65025, where the adder's carry bit is used, and a zero operand giving 0.
- R9: A request presented during the `done` cycle is accepted at once (`start_ready` is 1 then), and the new operation starts back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request to multiply the operands on the buses |
| start_ready | output | 1 | High while a request can be accepted |
| op_a | input | W | Multiplicand operand |
| op_b | input | W | Multiplier operand |
| product | output | 2W | Result register |
| done | output | 1 | One-cycle pulse marking a new product |

## Verification
On every cycle, the assertions check that a completed product matches the operands captured at the handshake. They also check that `done` lasts one cycle, that `product` holds outside `done`, that an accepted request drops `start_ready`, and that the iteration count stays in range. Only the bench scenarios can show the exact 2W+1-cycle latency and that a request made while busy is dropped rather than deferred. The same applies to operands that change after the handshake, the back-to-back start from the `done` cycle, and the boundary products that use the carry bit.

// File: rtl/shiftadd_mult_pkg.sv
`timescale 1ns/1ps
package shiftadd_mult_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADD,
    ST_SHIFT,
    ST_FIN,
    ST_DONE
  } ctl_state_t;

  // Moore outputs of the control unit toward the datapath
  typedef struct packed {
    logic m_en;    // multiplicand register enable
    logic m_mode;  // 1: parallel load, 0: shift path
    logic q_en;    // multiplier register enable
    logic q_mode;
    logic a_en;    // accumulator (with carry) enable
    logic a_mode;
    logic a_clr;   // accumulator parallel input forced to zero
    logic a_cond;  // accumulator write gated by multiplier bit 0
    logic p_en;    // result register enable
    logic done;
    logic ready;
  } ctl_bus_t;

endpackage

// File: rtl/shiftadd_mult_reg.sv
`timescale 1ns/1ps
module shiftadd_mult_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode,
  input  logic [W-1:0] d_bus,
  input  logic [W-1:0] d_shift,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= mode ? d_bus : d_shift;
  end

endmodule

// File: rtl/shiftadd_mult_dp.sv
`timescale 1ns/1ps
module shiftadd_mult_dp
  import shiftadd_mult_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_bus_t      ctl,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic [PW-1:0] product
);

  logic [W-1:0] m_q;
  logic [W-1:0] q_q;
  logic [W:0]   a_q;     // carry in the top bit
  logic [W:0]   sum;
  logic [W:0]   a_bus;
  logic [W:0]   a_shift;
  logic [W-1:0] q_shift;
  logic         a_en_g;

  assign sum     = {1'b0, a_q[W-1:0]} + {1'b0, m_q};
  assign a_bus   = ctl.a_clr ? '0 : sum;
  assign a_shift = {1'b0, a_q[W:1]};
  assign q_shift = {a_q[0], q_q[W-1:1]};
  assign a_en_g  = ctl.a_en & (~ctl.a_cond | q_q[0]);

  shiftadd_mult_reg #(.W(W)) u_mreg (
    .clk(clk), .rst_n(rst_n), .en(ctl.m_en), .mode(ctl.m_mode),
    .d_bus(op_a), .d_shift(m_q), .q(m_q)
  );

  shiftadd_mult_reg #(.W(W)) u_qreg (
    .clk(clk), .rst_n(rst_n), .en(ctl.q_en), .mode(ctl.q_mode),
    .d_bus(op_b), .d_shift(q_shift), .q(q_q)
  );

  shiftadd_mult_reg #(.W(W+1)) u_areg (
    .clk(clk), .rst_n(rst_n), .en(a_en_g), .mode(ctl.a_mode),
    .d_bus(a_bus), .d_shift(a_shift), .q(a_q)
  );

  shiftadd_mult_reg #(.W(PW)) u_preg (
    .clk(clk), .rst_n(rst_n), .en(ctl.p_en), .mode(1'b1),
    .d_bus({a_q[W-1:0], q_q}), .d_shift(product), .q(product)
  );

endmodule

// File: rtl/shiftadd_mult_ctrl.sv
`timescale 1ns/1ps
module shiftadd_mult_ctrl
  import shiftadd_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output ctl_bus_t      ctl,
  output logic [CW-1:0] loop_cnt
);

  ctl_state_t    st_q, st_d;
  logic [CW-1:0] cnt_d;
  logic          last;

  assign last = (loop_cnt == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      loop_cnt <= '0;
    end else begin
      st_q     <= st_d;
      loop_cnt <= cnt_d;
    end
  end

  // next state and next count; the count never reaches the outputs
  always_comb begin
    st_d  = st_q;
    cnt_d = loop_cnt;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        cnt_d = '0;
        st_d  = start_valid ? ST_ADD : ST_IDLE;
      end
      ST_ADD:   st_d = ST_SHIFT;
      ST_SHIFT: begin
        cnt_d = last ? '0 : loop_cnt + 1'b1;
        st_d  = last ? ST_FIN : ST_ADD;
      end
      ST_FIN:   st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Moore outputs: a function of st_q alone
  always_comb begin
    ctl = '0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        ctl.m_en   = 1'b1; ctl.m_mode = 1'b1;
        ctl.q_en   = 1'b1; ctl.q_mode = 1'b1;
        ctl.a_en   = 1'b1; ctl.a_mode = 1'b1; ctl.a_clr = 1'b1;
        ctl.ready  = 1'b1;
        ctl.done   = (st_q == ST_DONE);
      end
      ST_ADD: begin
        ctl.a_en   = 1'b1; ctl.a_mode = 1'b1; ctl.a_cond = 1'b1;
      end
      ST_SHIFT: begin
        ctl.q_en   = 1'b1; ctl.q_mode = 1'b0;
        ctl.a_en   = 1'b1; ctl.a_mode = 1'b0;
      end
      ST_FIN:   ctl.p_en = 1'b1;
      default:  ctl = '0;
    endcase
  end

endmodule

// File: rtl/shiftadd_mult.sv
`timescale 1ns/1ps
module shiftadd_mult
  import shiftadd_mult_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic [PW-1:0] product,
  output logic          done
);

  ctl_bus_t      ctl;
  logic [CW-1:0] loop_cnt;

  shiftadd_mult_ctrl #(.N(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .ctl(ctl), .loop_cnt(loop_cnt)
  );

  shiftadd_mult_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .op_a(op_a), .op_b(op_b), .product(product)
  );

  assign start_ready = ctl.ready;
  assign done        = ctl.done;

endmodule

// File: rtl/shiftadd_mult_chk.sv
`timescale 1ns/1ps
module shiftadd_mult_chk #(
  parameter int W = 8,
  localparam int PW = 2 * W,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_valid,
  input logic          start_ready,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [PW-1:0] product,
  input logic          done,
  input logic [CW-1:0] loop_cnt
);

  logic [W-1:0]  cap_a, cap_b;
  logic [PW-1:0] exp_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (start_valid && start_ready) begin
      cap_a <= op_a;
      cap_b <= op_b;
    end
  end

  assign exp_p = PW'(cap_a) * PW'(cap_b);

  // R1 R2: result matches operands captured at the handshake
  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == exp_p);

  // R5: one-cycle done
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: product holds outside the done cycle
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  // R3: an accepted request makes the block busy
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);

  // R9: the done cycle can accept a new request
  a_r9_ready_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);

  // R4: iteration count stays within the operand width
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(loop_cnt) < W);

endmodule

bind shiftadd_mult shiftadd_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
  .start_ready(start_ready), .op_a(op_a), .op_b(op_b),
  .product(product), .done(done), .loop_cnt(loop_cnt)
);

// File: tb/shiftadd_mult_bench.sv
`timescale 1ns/1ps
module shiftadd_mult_bench;

  localparam int W   = 8;
  localparam int PW  = 2 * W;
  localparam int LAT = 2 * W + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic [PW-1:0] product;
  logic          done;

  typedef struct {
    logic [PW-1:0] p;
    int            c;
  } exp_t;

  exp_t          sb[$];
  int            checks = 0;
  int            fails = 0;
  int            cyc = 0;
  logic [PW-1:0] last_p = '0;
  logic          prev_done = 1'b0;
  logic          mon_on = 1'b0;
  bit            finished = 1'b0;

  shiftadd_mult #(.W(W)) u_shiftadd_mult (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_ready(start_ready), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: called at a negedge; returns at a negedge after acceptance
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    start_valid = 1'b1;
    op_a = a;
    op_b = b;
    while (!start_ready) @(negedge clk);
    e.p = PW'(a) * PW'(b);
    e.c = cyc + 1 + LAT;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    op_a = ~a;                 // R2: bus changes after the handshake
    op_b = a ^ b ^ 8'h5a;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (done) begin
        if (prev_done) check(1'b0, "R5 done longer than one cycle", 1, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected result", 32'(product), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(product == e.p, "R1 product", 32'(product), 32'(e.p));
          check(cyc == e.c, "R4 latency", cyc, e.c);
        end
        last_p = product;
      end else begin
        check(product == last_p, "R6 product hold", 32'(product), 32'(last_p));
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: values during reset
    check(done == 1'b0, "R7 done in reset", 32'(done), 0);
    check(product == '0, "R7 product in reset", 32'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_ready == 1'b1, "R7 ready after reset", 32'(start_ready), 1);
    check(done == 1'b0, "R7 done after reset", 32'(done), 0);
    check(product == '0, "R7 product after reset", 32'(product), 0);
    mon_on = 1'b1;

    issue(8'd9, 8'd11);        // R1: 99
    issue(8'd255, 8'd255);     // R8: 65025, carry used
    issue(8'd0, 8'd200);       // R8: zero multiplicand
    issue(8'd200, 8'd0);       // R8: zero multiplier
    issue(8'd1, 8'd1);
    issue(8'd128, 8'd2);
    issue(8'd170, 8'd85);

    // R3: requests while busy are refused and leave no result
    issue(8'd3, 8'd5);
    start_valid = 1'b1;
    op_a = 8'd7;
    op_b = 8'd7;
    for (int i = 0; i < 6; i++) begin
      check(start_ready == 1'b0, "R3 ready while busy", 32'(start_ready), 0);
      @(negedge clk);
    end
    start_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    // R9: request presented in the done cycle starts at once
    issue(8'd13, 8'd17);
    while (!done) @(negedge clk);
    check(start_ready == 1'b1, "R9 ready in done cycle", 32'(start_ready), 1);
    issue(8'd254, 8'd129);
    issue(8'd77, 8'd25);

    while (sb.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);   // any stray done is reported by the monitor

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule